// File: doc/BRIEF.md
# Ping-Pong Block Transfer Engine

The block moves data between a processor register port and a byte-wide stream on the SCSI side. It always moves whole blocks of `BLK` bytes (128 by default) through two alternating buffers. While the processor fills or empties one buffer, the stream side works on the other.

Software sets the direction in the control/status register and then writes a number of blocks into the block-count register, which starts the transfer. The engine then reports through one status flag when the processor may move the next buffer. The block count falls by one for each block that crosses the stream side.

While a transfer runs, the core-access bit (bit 7) is held low. It rises again only when the transfer completes or when software aborts it with the reset bit. An interrupt raised by the stream side during a transfer is latched as a gated-interrupt flag and freezes the stream side.

Top module: `pdma_blk_engine`

## Requirements
- R1: After reset, the control/status register (select 0) reads 0x0084: bit 7 (core access) = 1, bit 2 (host buffer not ready) = 1, and bit 0 (direction), bit 3 (gated interrupt) and bit 4 (end of transfer) = 0. The block-count register (select 1) reads 0, and both `end_of_dma` and `last_byte_sent` are low.
- R2: Writing a nonzero N to the block-count register while idle starts a transfer: the count reads N and bit 7 clears. Writing zero is ignored and the engine stays idle.
- R3: In send mode (bit 0 = 0), bytes written to the data port (select 2) leave on `scsi_tx_data` in write order, exactly N*BLK of them, one per cycle with `scsi_tx_valid` and `scsi_tx_ready` both high.
- R4: In receive mode (bit 0 = 1), bytes taken on `scsi_rx_data` (while `scsi_rx_valid` and `scsi_rx_ready` are high) are returned by data-port reads in arrival order.
- R5: A data-port access with `reg_wide` = 1 moves two bytes: the lower-addressed byte is on bits 7:0 and the next byte on bits 15:8.
- R6: With the stream side stalled during a send, the host can fill exactly two blocks before bit 2 sets. Bit 2 clears again once the stream side has drained one block.
- R7: The block count decrements by one for each BLK bytes that cross the stream side, and never on a host access.
- R8: A send completes when the count reaches 0. At that point `end_of_dma`, `last_byte_sent`, bit 4 and bit 7 all set.
- R9: A receive sets `end_of_dma` only after the host has read the final block, not when the count reaches 0. `last_byte_sent` stays low.
- R10: `scsi_irq` during a transfer sets bit 3 and stops all further stream handshakes. Bit 7 stays low.
- R11: Writing bit 1 (reset) of the control/status register aborts the transfer: the count reads 0, bit 7 sets, bit 3 clears, both buffers become empty, and bit 2 reads 1.
- R12: Data-port accesses while bit 2 is set, count writes during a transfer, and direction writes during a transfer are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control/status, 1 block count, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops data in receive mode) |
| reg_wide | input | 1 | Data access is 16 bits |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational) |
| scsi_tx_valid | output | 1 | Send byte available |
| scsi_tx_data | output | 8 | Send byte |
| scsi_tx_ready | input | 1 | Stream side takes the send byte |
| scsi_rx_valid | input | 1 | Receive byte offered |
| scsi_rx_data | input | 8 | Receive byte |
| scsi_rx_ready | output | 1 | Engine accepts a receive byte |
| scsi_irq | input | 1 | Stream-side interrupt |
| end_of_dma | output | 1 | Transfer finished (sticky until next start or abort) |
| last_byte_sent | output | 1 | Final send byte left (sticky) |

## Verification
The bench builds the engine with BLK = 8 and CNT_W = 4. With blocks this small, every block count from 1 to 4 can be swept in both directions and with both access widths. The same setting keeps the both-buffers-full stall, the receive end-of-transfer ordering, the mid-transfer interrupt and the abort each within a few dozen cycles. A stub on the stream side throttles its handshakes in a fixed cycle pattern, so ping-pong overlap and back-pressure both occur.

// File: rtl/pdma_pkg.sv
// Shared register selects and control/status bit positions for the block engine.
package pdma_pkg;
    typedef enum logic [1:0] {
        SEL_CSR  = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_DATA = 2'd2
    } reg_sel_e;

    localparam int CSR_DIR  = 0;
    localparam int CSR_RST  = 1;
    localparam int CSR_NRDY = 2;
    localparam int CSR_GIRQ = 3;
    localparam int CSR_EOD  = 4;
    localparam int CSR_ACC  = 7;
endpackage

// File: rtl/pdma_side_ptr.sv
// Byte index and bank select for one side of the ping-pong buffer.
// Assumes BLK is a power of two, and that wide steps start on even indices.
module pdma_side_ptr #(
    parameter int BLK = 128,
    parameter int IW  = $clog2(BLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic          wide,
    output logic [IW-1:0] idx,
    output logic          bank,
    output logic          blk_end
);
    logic [IW:0] nxt;

    // Next index and end-of-block detection for the current step.
    always_comb begin
        nxt     = {1'b0, idx} + (wide ? (IW+1)'(2) : (IW+1)'(1));
        blk_end = step && (nxt == (IW+1)'(BLK));
    end

    // Advance the index; on block end, wrap to 0 and switch banks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx  <= '0;
            bank <= 1'b0;
        end else if (step) begin
            if (blk_end) begin
                idx  <= '0;
                bank <= ~bank;
            end else begin
                idx  <= nxt[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/pdma_bank_store.sv
// Two BLK-byte banks. The host port works in bytes or 16-bit pairs (low byte first);
// the stream port works in bytes. Assumes the two ports never write the same bank
// in one cycle.
module pdma_bank_store #(
    parameter int BLK = 128,
    parameter int IW  = $clog2(BLK)
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic          h_wide,
    input  logic          h_bank,
    input  logic [IW-1:0] h_idx,
    input  logic [15:0]   h_wdata,
    output logic [15:0]   h_rdata,
    input  logic          s_we,
    input  logic          s_bank,
    input  logic [IW-1:0] s_idx,
    input  logic [7:0]    s_wdata,
    output logic [7:0]    s_rdata
);
    localparam int DEPTH = 2 * BLK;

    logic [7:0]    mem [DEPTH];
    logic [IW-1:0] h_idx_hi;

    // Host read is a byte pair; stream read is one byte.
    always_comb begin
        h_idx_hi = h_idx + IW'(1);
        h_rdata  = {mem[{h_bank, h_idx_hi}], mem[{h_bank, h_idx}]};
        s_rdata  = mem[{s_bank, s_idx}];
    end

    // Write from whichever side owns its bank this cycle.
    always_ff @(posedge clk) begin
        if (h_we) begin
            mem[{h_bank, h_idx}] <= h_wdata[7:0];
            if (h_wide) begin
                mem[{h_bank, h_idx_hi}] <= h_wdata[15:8];
            end
        end
        if (s_we) begin
            mem[{s_bank, s_idx}] <= s_wdata;
        end
    end
endmodule

// File: rtl/pdma_ctrl.sv
// Transfer controller: bank full flags, block counts, interrupt halt, completion
// flags and the core-access lockout. Assumes the block-end strobes come from the
// side pointers and are already gated by readiness.
module pdma_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic             csr_dir_bit,
    input  logic             csr_rst_bit,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             host_blk_end,
    input  logic             scsi_blk_end,
    input  logic             host_bank,
    input  logic             scsi_bank,
    input  logic             scsi_irq,
    output logic             dir_rx,
    output logic             active,
    output logic             halted,
    output logic             core_access,
    output logic             end_of_dma,
    output logic             last_byte_sent,
    output logic [CNT_W-1:0] blk_cnt,
    output logic             host_nrdy,
    output logic             scsi_go,
    output logic             start,
    output logic             abort
);
    logic [1:0]       full;
    logic [CNT_W-1:0] host_rem;

    // Decode the start and abort events from register writes.
    always_comb begin
        abort = csr_we && csr_rst_bit;
        start = cnt_we && !active && !abort && (cnt_wdata != '0);
    end

    // Readiness of the host buffer and of the stream side.
    always_comb begin
        if (dir_rx) begin
            host_nrdy = !active || !full[host_bank];
            scsi_go   = active && !halted && !full[scsi_bank] && (blk_cnt != '0);
        end else begin
            host_nrdy = !active || full[host_bank] || (host_rem == '0);
            scsi_go   = active && !halted && full[scsi_bank];
        end
    end

    // Direction is writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_rx <= 1'b0;
        end else if (csr_we && !csr_rst_bit && !active) begin
            dir_rx <= csr_dir_bit;
        end
    end

    // Transfer state: start, abort, block accounting and completion.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            active         <= 1'b0;
            halted         <= 1'b0;
            core_access    <= 1'b1;
            end_of_dma     <= 1'b0;
            last_byte_sent <= 1'b0;
            full           <= 2'b00;
            blk_cnt        <= '0;
            host_rem       <= '0;
        end else if (start) begin
            active         <= 1'b1;
            halted         <= 1'b0;
            core_access    <= 1'b0;
            end_of_dma     <= 1'b0;
            last_byte_sent <= 1'b0;
            full           <= 2'b00;
            blk_cnt        <= cnt_wdata;
            host_rem       <= cnt_wdata;
        end else if (active) begin
            if (scsi_irq) begin
                halted <= 1'b1;
            end
            if (host_blk_end) begin
                full[host_bank] <= !dir_rx;
                host_rem        <= host_rem - 1'b1;
            end
            if (scsi_blk_end) begin
                full[scsi_bank] <= dir_rx;
                blk_cnt         <= blk_cnt - 1'b1;
            end
            if (!dir_rx && scsi_blk_end && (blk_cnt == CNT_W'(1))) begin
                active         <= 1'b0;
                core_access    <= 1'b1;
                end_of_dma     <= 1'b1;
                last_byte_sent <= 1'b1;
            end
            if (dir_rx && host_blk_end && (host_rem == CNT_W'(1))) begin
                active      <= 1'b0;
                core_access <= 1'b1;
                end_of_dma  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pdma_blk_engine.sv
// Ping-pong block transfer engine top: register decode, host and stream pointers,
// the two-bank store and the transfer controller. Assumes BLK is an even power of
// two and CNT_W <= 16.
module pdma_blk_engine
    import pdma_pkg::*;
#(
    parameter int BLK   = 128,
    parameter int CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        reg_wide,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        scsi_tx_valid,
    output logic [7:0]  scsi_tx_data,
    input  logic        scsi_tx_ready,
    input  logic        scsi_rx_valid,
    input  logic [7:0]  scsi_rx_data,
    output logic        scsi_rx_ready,
    input  logic        scsi_irq,
    output logic        end_of_dma,
    output logic        last_byte_sent
);
    localparam int IW = $clog2(BLK);

    logic             csr_we, cnt_we, data_sel;
    logic             dir_rx, active, halted, core_access;
    logic [CNT_W-1:0] blk_cnt;
    logic             host_nrdy, scsi_go, start, abort;
    logic             host_step, scsi_step, ptr_clr;
    logic [IW-1:0]    h_idx, s_idx;
    logic             h_bank, s_bank, h_end, s_end;
    logic [15:0]      h_rdata;
    logic [7:0]       s_rdata;

    // Register write decode and accepted host/stream transfer steps.
    always_comb begin
        csr_we    = reg_wr && (reg_sel == SEL_CSR);
        cnt_we    = reg_wr && (reg_sel == SEL_CNT);
        data_sel  = (reg_sel == SEL_DATA);
        host_step = !host_nrdy && data_sel && (dir_rx ? reg_rd : reg_wr);
        scsi_step = scsi_go && (dir_rx ? scsi_rx_valid : scsi_tx_ready);
        ptr_clr   = start || abort;
    end

    // Host-side pointer (byte or 16-bit steps).
    pdma_side_ptr #(.BLK(BLK), .IW(IW)) u_hptr (
        .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .step(host_step), .wide(reg_wide),
        .idx(h_idx), .bank(h_bank), .blk_end(h_end)
    );

    // Stream-side pointer (byte steps only).
    pdma_side_ptr #(.BLK(BLK), .IW(IW)) u_sptr (
        .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .step(scsi_step), .wide(1'b0),
        .idx(s_idx), .bank(s_bank), .blk_end(s_end)
    );

    pdma_bank_store #(.BLK(BLK), .IW(IW)) u_store (
        .clk(clk),
        .h_we(host_step && !dir_rx), .h_wide(reg_wide), .h_bank(h_bank),
        .h_idx(h_idx), .h_wdata(reg_wdata), .h_rdata(h_rdata),
        .s_we(scsi_step && dir_rx), .s_bank(s_bank), .s_idx(s_idx),
        .s_wdata(scsi_rx_data), .s_rdata(s_rdata)
    );

    pdma_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .csr_we(csr_we), .csr_dir_bit(reg_wdata[CSR_DIR]), .csr_rst_bit(reg_wdata[CSR_RST]),
        .cnt_we(cnt_we), .cnt_wdata(reg_wdata[CNT_W-1:0]),
        .host_blk_end(h_end), .scsi_blk_end(s_end),
        .host_bank(h_bank), .scsi_bank(s_bank), .scsi_irq(scsi_irq),
        .dir_rx(dir_rx), .active(active), .halted(halted), .core_access(core_access),
        .end_of_dma(end_of_dma), .last_byte_sent(last_byte_sent), .blk_cnt(blk_cnt),
        .host_nrdy(host_nrdy), .scsi_go(scsi_go), .start(start), .abort(abort)
    );

    // Stream-side outputs.
    always_comb begin
        scsi_tx_valid = scsi_go && !dir_rx;
        scsi_tx_data  = s_rdata;
        scsi_rx_ready = scsi_go && dir_rx;
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CSR: begin
                reg_rdata[CSR_DIR]  = dir_rx;
                reg_rdata[CSR_NRDY] = host_nrdy;
                reg_rdata[CSR_GIRQ] = halted;
                reg_rdata[CSR_EOD]  = end_of_dma;
                reg_rdata[CSR_ACC]  = core_access;
            end
            SEL_CNT:  reg_rdata = 16'(blk_cnt);
            SEL_DATA: reg_rdata = (dir_rx && !host_nrdy) ? h_rdata : 16'h0000;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pdma_blk_engine_chk.sv
// Protocol checker for the block engine, bound to the top module.
module pdma_blk_engine_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             abort,
    input logic             active,
    input logic             core_access,
    input logic [CNT_W-1:0] cnt,
    input logic             gated,
    input logic             eod,
    input logic             lbs,
    input logic             tx_valid,
    input logic             rx_ready
);
    a_r2_access_locked: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !core_access);

    a_r7_count_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !abort) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

    a_r8_lbs_with_eod: assert property (@(posedge clk) disable iff (!rst_n)
        lbs |-> (eod && core_access));

    a_r9_eod_idle: assert property (@(posedge clk) disable iff (!rst_n)
        eod |-> !active);

    a_r10_halt_stream: assert property (@(posedge clk) disable iff (!rst_n)
        gated |-> (!tx_valid && !rx_ready));

    a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (cnt == '0 && core_access && !gated && !active));
endmodule

bind pdma_blk_engine pdma_blk_engine_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .active(active),
    .core_access(core_access), .cnt(blk_cnt), .gated(halted), .eod(end_of_dma),
    .lbs(last_byte_sent), .tx_valid(scsi_tx_valid), .rx_ready(scsi_rx_ready)
);

// File: tb/pdma_blk_engine_tb.sv
// Sweep bench for the block engine with 8-byte blocks and a throttled stream stub.
module pdma_blk_engine_tb;
    localparam int BLK   = 8;
    localparam int CNT_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_wide = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        scsi_tx_valid, scsi_rx_ready;
    logic [7:0]  scsi_tx_data;
    logic        scsi_tx_ready = 1'b0;
    logic        scsi_rx_valid = 1'b0;
    logic [7:0]  scsi_rx_data = '0;
    logic        scsi_irq = 1'b0;
    logic        end_of_dma, last_byte_sent;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int ntx = 0, tx_mism = 0, tx_base = 0;
    int nrx = 0, rx_base = 0;
    logic tx_stall = 1'b0, rx_en = 1'b0;

    always #10 clk = ~clk;

    pdma_blk_engine #(.BLK(BLK), .CNT_W(CNT_W)) u_dut (.*);

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 29 + 7) & 8'hff);
    endfunction

    // Stream stub: throttled ready/valid, capture and compare of sent bytes.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (scsi_tx_valid && scsi_tx_ready) begin
            if (scsi_tx_data != pat(ntx - tx_base)) tx_mism = tx_mism + 1;
            ntx = ntx + 1;
        end
        if (scsi_rx_valid && scsi_rx_ready) nrx = nrx + 1;
    end

    always @(negedge clk) begin
        scsi_tx_ready = !tx_stall && (cyc % 3 != 0);
        scsi_rx_valid = rx_en && (cyc % 4 != 1);
        scsi_rx_data  = pat(nrx - rx_base);
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d, input logic wide);
        reg_sel = sel; reg_wdata = d; reg_wide = wide; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wide = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic pop(input logic wide, output logic [15:0] v);
        reg_sel = 2'd2; reg_wide = wide; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_wide = 1'b0;
    endtask

    task automatic wait_ready();
        logic [15:0] c;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd0, c);
            if (!c[2]) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_eod();
        for (int i = 0; i < 2000; i++) begin
            if (end_of_dma) break;
            @(negedge clk);
        end
    endtask

    task automatic run_tx(input int n, input logic wide);
        logic [15:0] v;
        int st = wide ? 2 : 1;
        tx_base = ntx; tx_mism = 0;
        wr(2'd0, 16'h0000, 1'b0);
        wr(2'd1, 16'(n), 1'b0);
        rd(2'd1, v);  check(v == 16'(n), "R2 count loaded", v, n);
        rd(2'd0, v);  check(v[7] == 1'b0, "R2 access locked", v[7], 0);
        for (int k = 0; k < n * BLK; k += st) begin
            wait_ready();
            wr(2'd2, {pat(k + 1), pat(k)}, wide);
        end
        wait_eod();
        check(ntx - tx_base == n * BLK, "R3 send byte count", ntx - tx_base, n * BLK);
        check(tx_mism == 0, wide ? "R5 wide send data" : "R3 send data", tx_mism, 0);
        check(end_of_dma && last_byte_sent, "R8 send flags", {end_of_dma, last_byte_sent}, 3);
        rd(2'd0, v);  check(v[7] && v[4], "R8 access and eod bits", v, 16'h0090);
        rd(2'd1, v);  check(v == 16'd0, "R7 count at end", v, 0);
    endtask

    task automatic run_rx(input int n, input logic wide);
        logic [15:0] v;
        int st = wide ? 2 : 1;
        int bad = 0;
        rx_base = nrx;
        wr(2'd0, 16'h0001, 1'b0);
        wr(2'd1, 16'(n), 1'b0);
        rx_en = 1'b1;
        for (int k = 0; k < (n - 1) * BLK; k += st) begin
            wait_ready();
            pop(wide, v);
            if (v[7:0] != pat(k) || (wide && v[15:8] != pat(k + 1))) bad++;
        end
        for (int i = 0; i < 2000; i++) begin
            rd(2'd1, v);
            if (v == 16'd0) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        check(end_of_dma == 1'b0, "R9 no eod before last drain", end_of_dma, 0);
        for (int k = (n - 1) * BLK; k < n * BLK; k += st) begin
            wait_ready();
            pop(wide, v);
            if (v[7:0] != pat(k) || (wide && v[15:8] != pat(k + 1))) bad++;
        end
        rx_en = 1'b0;
        check(bad == 0, wide ? "R5 wide receive data" : "R4 receive data", bad, 0);
        check(end_of_dma && !last_byte_sent, "R9 receive flags",
              {end_of_dma, last_byte_sent}, 2);
        rd(2'd0, v);  check(v[7] == 1'b1, "R9 access after receive", v[7], 1);
    endtask

    initial begin
        logic [15:0] v;
        int wcount, seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v);  check(v == 16'h0084, "R1 csr reset", v, 16'h0084);
        rd(2'd1, v);  check(v == 16'd0, "R1 count reset", v, 0);
        check(!end_of_dma && !last_byte_sent, "R1 flags reset", end_of_dma, 0);
        // R2 zero count ignored
        wr(2'd1, 16'd0, 1'b0);
        rd(2'd0, v);  check(v == 16'h0084, "R2 zero count ignored", v, 16'h0084);

        for (int n = 1; n <= 4; n++) begin
            run_tx(n, 1'b0);
            run_tx(n, 1'b1);
            run_rx(n, 1'b0);
            run_rx(n, 1'b1);
        end

        // R6 ping-pong stall with ignored accesses (R12)
        tx_stall = 1'b1;
        tx_base = ntx; tx_mism = 0;
        wr(2'd0, 16'h0000, 1'b0);
        wr(2'd1, 16'd3, 1'b0);
        wcount = 0;
        for (int k = 0; k < 3 * BLK; k++) begin
            rd(2'd0, v);
            if (v[2]) break;
            wr(2'd2, {8'h00, pat(k)}, 1'b0);
            wcount++;
        end
        check(wcount == 2 * BLK, "R6 two blocks accepted", wcount, 2 * BLK);
        rd(2'd1, v);  check(v == 16'd3, "R7 no decrement on host fill", v, 3);
        wr(2'd2, 16'h00EE, 1'b0);
        wr(2'd1, 16'd9, 1'b0);
        rd(2'd1, v);  check(v == 16'd3, "R12 count write ignored", v, 3);
        wr(2'd0, 16'h0001, 1'b0);
        rd(2'd0, v);  check(v[0] == 1'b0, "R12 dir write ignored", v[0], 0);
        tx_stall = 1'b0;
        for (int i = 0; i < 500; i++) begin
            rd(2'd1, v);
            if (v == 16'd2) break;
            @(negedge clk);
        end
        rd(2'd0, v);  check(v[2] == 1'b0, "R6 ready after one drained", v[2], 0);
        for (int k = 2 * BLK; k < 3 * BLK; k++) begin
            wait_ready();
            wr(2'd2, {8'h00, pat(k)}, 1'b0);
        end
        wait_eod();
        check(tx_mism == 0 && ntx - tx_base == 3 * BLK, "R12 ignored data write",
              tx_mism, 0);

        // R10 gated interrupt, then R11 abort
        rx_base = nrx;
        wr(2'd0, 16'h0001, 1'b0);
        wr(2'd1, 16'd3, 1'b0);
        rx_en = 1'b1;
        for (int i = 0; i < 500; i++) begin
            if (nrx - rx_base >= 3) break;
            @(negedge clk);
        end
        scsi_irq = 1'b1;
        @(negedge clk);
        scsi_irq = 1'b0;
        seen = nrx;
        repeat (20) @(negedge clk);
        check(nrx == seen, "R10 stream halted", nrx, seen);
        rd(2'd0, v);  check(v[3] && !v[7], "R10 gated set, access low", v, 16'h0008);
        rx_en = 1'b0;
        wr(2'd0, 16'h0002, 1'b0);
        rd(2'd1, v);  check(v == 16'd0, "R11 count cleared", v, 0);
        rd(2'd0, v);  check(v == 16'h0085, "R11 csr after abort", v, 16'h0085);
        check(!end_of_dma, "R11 no eod on abort", end_of_dma, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule